// File: doc/BRIEF.md
# Multi-size translation lookaside buffer

This block is a small, fully associative cache of address translations. A requester presents a 32-bit virtual address and learns in the same cycle whether a stored mapping covers it. On a hit it also gets the physical address. Each entry holds its own mapping size: 4 KB, 64 KB, 1 MB or 16 MB. The size sets how many high address bits take part in the compare. It also sets where the physical address switches from the stored frame to the incoming address bits.

On a miss the block raises a request to an external table walker and latches the address that missed. It holds the request until the walker hands back a fill. A fill is written into a free entry when one exists, otherwise into the entry chosen by a round-robin pointer. When translation tables change, software-visible control can drop stale mappings. It can drop every entry covering a given address, or all entries at once.

Top module: `multisize_tlb`

## Requirements
- R1: After reset no entry is valid, `walk_req` is low, and `lk_hit` is low for any lookup; `lk_hit` is low whenever `lk_valid` is low.
- R2: A lookup reports `lk_hit` and `lk_pa` combinationally in the cycle `lk_valid` is high. For a 4 KB entry (size code 0), the compare uses VA[31:12], and `lk_pa` is the stored frame bits [31:12] joined with VA[11:0].
- R3: A 64 KB entry (size code 1) matches any VA whose bits [31:16] equal the stored tag's bits [31:16]. Its `lk_pa` takes frame bits [31:16] and VA[15:0].
- R4: A 1 MB entry (code 2) compares VA[31:20] and passes VA[19:0] through. A 16 MB entry (code 3) compares VA[31:24] and passes VA[23:0] through. Stored low tag and frame bits below the boundary have no effect.
- R5: A lookup miss while no walk is pending sets `walk_req` and loads `walk_va` with the missing VA at the next clock edge. Both hold, and later misses do not change `walk_va`, until a fill is accepted.
- R6: A cycle with `fill_valid` high clears `walk_req` at the next edge. The filled mapping is available to lookups from the following cycle.
- R7: A fill is written into the lowest-numbered invalid entry when any entry is invalid, and no valid entry is displaced.
- R8: When all entries are valid, a fill replaces the entry at a round-robin pointer, which then advances by one and wraps. The pointer starts at entry 0 after reset and moves only on such replacing fills.
- R9: Invalidate-by-address (`inv_va_valid` with `inv_vpn` = VA[31:12]) clears every valid entry whose size-masked tag matches. Entries of other sizes or regions are kept.
- R10: `inv_all` clears every entry at the next edge.
- R11: When `inv_all` and `fill_valid` are high in the same cycle, the fill is dropped. When `inv_va_valid` and `fill_valid` are high together, the invalidate applies to the old contents and the fill is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_pa | output | 32 | Translated physical address, valid with lk_hit |
| walk_req | output | 1 | Walk request, held until a fill |
| walk_va | output | 32 | Virtual address that missed |
| fill_valid | input | 1 | Walker returns a mapping |
| fill_vpn | input | 20 | Fill virtual page bits VA[31:12] |
| fill_frame | input | 20 | Fill physical frame bits PA[31:12] |
| fill_size | input | 2 | Fill size code: 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| inv_va_valid | input | 1 | Invalidate entries covering inv_vpn |
| inv_vpn | input | 20 | Address bits VA[31:12] to invalidate |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench probes both edges of each page size. It tests the last address inside a region and the first address beyond it. A design with the wrong mask would hit past the region or return frame bits in place of offset bits. It fills all eight entries and then keeps filling, and it punches a hole with an address invalidate in between. A victim chooser that ignores free slots, or a pointer that moves on free-slot fills, would then evict the wrong survivor. Mixed-size invalidates check that a large page falls to an address deep inside it while a small page nearby stays. Same-cycle invalidate-plus-fill cases check that the fill is dropped only under invalidate-all.

// File: rtl/mstlb_pkg.sv
package mstlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2,
    PG_16M = 2'd3
  } pg_size_e;

  // Ones mark the page-number bits that take part in the compare.
  function automatic logic [VPN_W-1:0] vpn_mask(input pg_size_e sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      PG_4K:   m = '1;
      PG_64K:  m = {{(VPN_W-4){1'b1}},  4'h0};
      PG_1M:   m = {{(VPN_W-8){1'b1}},  8'h00};
      default: m = {{(VPN_W-12){1'b1}}, 12'h000};
    endcase
    return m;
  endfunction
endpackage

// File: rtl/mstlb_entry.sv
module mstlb_entry
  import mstlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [VPN_W-1:0] wr_frame,
  input  pg_size_e         wr_size,
  input  logic             inv_all,
  input  logic             inv_va_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             valid,
  output logic             match,
  output logic [VPN_W-1:0] pa_vpn
);
  logic             valid_q, valid_d;
  logic [VPN_W-1:0] tag_q, frame_q;
  pg_size_e         size_q;
  logic [VPN_W-1:0] mask;
  logic             inv_hit;

  assign mask    = vpn_mask(size_q);
  assign inv_hit = valid_q && (((inv_vpn ^ tag_q) & mask) == '0);
  assign match   = valid_q && (((lk_vpn ^ tag_q) & mask) == '0);
  assign pa_vpn  = (frame_q & mask) | (lk_vpn & ~mask);
  assign valid   = valid_q;

  always_comb begin
    valid_d = valid_q;
    if (inv_va_valid && inv_hit) valid_d = 1'b0;
    if (wr_en)                   valid_d = 1'b1;
    if (inv_all)                 valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q   <= wr_vpn;
      frame_q <= wr_frame;
      size_q  <= wr_size;
    end
  end

  a_r10_inv_all_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !valid);
  a_r6_no_spont_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !wr_en) |=> !valid);
endmodule

// File: rtl/mstlb_victim.sv
module mstlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               fill_en,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim = any_free ? free_idx : ptr_q;

  always_comb begin
    ptr_d = ptr_q;
    if (fill_en && !any_free)
      ptr_d = (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_comb begin
    if (rst_n && fill_en && (valid_vec != '1))
      a_r7_free_slot_used: assert (!valid_vec[victim]);
  end
  a_r8_ptr_moves_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && (valid_vec == '1)) |=> $stable(ptr_q));
endmodule

// File: rtl/multisize_tlb.sv
module multisize_tlb
  import mstlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [VA_W-1:0]  lk_pa,
  output logic             walk_req,
  output logic [VA_W-1:0]  walk_va,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_frame,
  input  logic [1:0]       fill_size,
  input  logic             inv_va_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             inv_all
);
  logic [ENTRIES-1:0] valid_vec, match_vec, wr_vec;
  logic [VPN_W-1:0]   pa_vpn [ENTRIES];
  logic [IDX_W-1:0]   victim, sel;
  logic               hit_any, fill_en, miss_start;
  logic               walk_req_q, walk_req_d;
  logic [VA_W-1:0]    walk_va_q, walk_va_d;

  assign fill_en = fill_valid && !inv_all;

  mstlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
    .fill_en(fill_en), .victim(victim)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_vec[g] = fill_en && (victim == IDX_W'(g));
    mstlb_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_vec[g]), .wr_vpn(fill_vpn), .wr_frame(fill_frame),
      .wr_size(pg_size_e'(fill_size)),
      .inv_all(inv_all), .inv_va_valid(inv_va_valid), .inv_vpn(inv_vpn),
      .lk_vpn(lk_va[VA_W-1:OFF_W]),
      .valid(valid_vec[g]), .match(match_vec[g]), .pa_vpn(pa_vpn[g])
    );
  end

  // Lowest matching index wins.
  always_comb begin
    hit_any = 1'b0;
    sel     = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit_any = 1'b1;
        sel     = IDX_W'(i);
      end
    end
  end

  assign lk_hit = lk_valid && hit_any;
  assign lk_pa  = {pa_vpn[sel], lk_va[OFF_W-1:0]};

  assign miss_start = lk_valid && !hit_any && !walk_req_q;

  always_comb begin
    walk_req_d = walk_req_q;
    walk_va_d  = walk_va_q;
    if (miss_start) begin
      walk_req_d = 1'b1;
      walk_va_d  = lk_va;
    end
    if (fill_valid) walk_req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) walk_req_q <= 1'b0;
    else        walk_req_q <= walk_req_d;
  end

  always_ff @(posedge clk) begin
    if (miss_start) walk_va_q <= walk_va_d;
  end

  assign walk_req = walk_req_q;
  assign walk_va  = walk_va_q;

  a_r5_miss_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit && !walk_req && !fill_valid) |=> (walk_req && walk_va == $past(lk_va)));
  a_r5_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !fill_valid) |=> (walk_req && $stable(walk_va)));
  a_r6_fill_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> !walk_req);
  a_r1_no_hit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit);
endmodule

// File: tb/multisize_tlb_test.sv
module multisize_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_va;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic        walk_req;
  logic [31:0] walk_va;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_frame;
  logic [1:0]  fill_size;
  logic        inv_va_valid;
  logic [19:0] inv_vpn;
  logic        inv_all;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  multisize_tlb uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_hit(lk_hit), .lk_pa(lk_pa), .walk_req(walk_req), .walk_va(walk_va),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
    .fill_size(fill_size), .inv_va_valid(inv_va_valid), .inv_vpn(inv_vpn),
    .inv_all(inv_all)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input bit eh, input logic [31:0] ep, input string r);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_va    = va;
    #1;
    chk(r, {31'd0, lk_hit}, {31'd0, eh});
    if (eh) chk(r, lk_pa, ep);
    @(posedge clk);
    #1 lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [31:0] va, input logic [31:0] pa, input logic [1:0] sz,
                      input bit with_inv_all, input bit with_inv_va, input logic [31:0] iva);
    @(negedge clk);
    fill_valid   = 1'b1;
    fill_vpn     = va[31:12];
    fill_frame   = pa[31:12];
    fill_size    = sz;
    inv_all      = with_inv_all;
    inv_va_valid = with_inv_va;
    inv_vpn      = iva[31:12];
    @(posedge clk);
    #1;
    fill_valid = 1'b0; inv_all = 1'b0; inv_va_valid = 1'b0;
  endtask

  task automatic inval(input bit all, input logic [31:0] va);
    @(negedge clk);
    inv_all      = all;
    inv_va_valid = !all;
    inv_vpn      = va[31:12];
    @(posedge clk);
    #1;
    inv_all = 1'b0; inv_va_valid = 1'b0;
  endtask

  function automatic logic [31:0] rva(input int i);
    return 32'h4000_0000 + (i << 12);
  endfunction
  function automatic logic [31:0] rpa(input int i);
    return 32'h8000_0000 + (i << 12);
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 walk_req", {31'd0, walk_req}, 32'd0);
    lk_valid = 1'b0; lk_va = 32'h0;
    #1 chk("R1 hit idle", {31'd0, lk_hit}, 32'd0);
    look(32'h1234_5678, 1'b0, 32'h0, "R1 empty miss");
    fill(32'h0000_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic t_replace;
    for (int i = 0; i < 8; i++) fill(rva(i), rpa(i), 2'd0, 1'b0, 1'b0, 32'h0);
    for (int i = 0; i < 8; i++) look(rva(i) + 32'h10, 1'b1, rpa(i) + 32'h10, "R7 fill free");
    fill(rva(8), rpa(8), 2'd0, 1'b0, 1'b0, 32'h0);
    look(rva(0), 1'b0, 32'h0, "R8 evict slot0");
    look(rva(1), 1'b1, rpa(1), "R8 keep slot1");
    look(rva(8), 1'b1, rpa(8), "R8 new entry");
    fill(rva(9), rpa(9), 2'd0, 1'b0, 1'b0, 32'h0);
    look(rva(1), 1'b0, 32'h0, "R8 evict slot1");
    inval(1'b0, rva(5));
    look(rva(5), 1'b0, 32'h0, "R9 single inval");
    fill(rva(10), rpa(10), 2'd0, 1'b0, 1'b0, 32'h0);
    look(rva(10), 1'b1, rpa(10), "R7 hole filled");
    look(rva(2), 1'b1, rpa(2), "R7 slot2 kept");
    look(rva(6), 1'b1, rpa(6), "R7 slot6 kept");
    fill(rva(11), rpa(11), 2'd0, 1'b0, 1'b0, 32'h0);
    look(rva(2), 1'b0, 32'h0, "R8 ptr resumed slot2");
    look(rva(3), 1'b1, rpa(3), "R8 slot3 kept");
    look(rva(10), 1'b1, rpa(10), "R8 slot5 kept");
    look(rva(11), 1'b1, rpa(11), "R8 newest");
    inval(1'b1, 32'h0);
  endtask

  task automatic t_sizes;
    fill(32'h0000_3000, 32'hFFFF_E000, 2'd0, 1'b0, 1'b0, 32'h0);
    look(32'h0000_3ABC, 1'b1, 32'hFFFF_EABC, "R2 4K hit");
    look(32'h0000_4000, 1'b0, 32'h0, "R2 4K next page");
    fill(32'h1234_0000, 32'h00AB_0000, 2'd1, 1'b0, 1'b0, 32'h0);
    look(32'h1234_FFFC, 1'b1, 32'h00AB_FFFC, "R3 64K top");
    look(32'h1235_0000, 1'b0, 32'h0, "R3 64K beyond");
    fill(32'h345A_B000, 32'h077F_F000, 2'd2, 1'b0, 1'b0, 32'h0);
    look(32'h345C_DEF0, 1'b1, 32'h077C_DEF0, "R4 1M splice");
    look(32'h3460_0000, 1'b0, 32'h0, "R4 1M beyond");
    fill(32'h5600_0000, 32'h9A00_0000, 2'd3, 1'b0, 1'b0, 32'h0);
    look(32'h56FF_FFFF, 1'b1, 32'h9AFF_FFFF, "R4 16M top");
    look(32'h5700_0000, 1'b0, 32'h0, "R4 16M beyond");
    inval(1'b1, 32'h0);
  endtask

  task automatic t_walk;
    fill(32'h0, 32'h0, 2'd0, 1'b1, 1'b0, 32'h0);
    look(32'h6000_1234, 1'b0, 32'h0, "R5 miss");
    @(negedge clk);
    chk("R5 req raised", {31'd0, walk_req}, 32'd1);
    chk("R5 walk_va", walk_va, 32'h6000_1234);
    look(32'h6100_0000, 1'b0, 32'h0, "R5 second miss");
    @(negedge clk);
    chk("R5 walk_va held", walk_va, 32'h6000_1234);
    chk("R5 req held", {31'd0, walk_req}, 32'd1);
    fill(32'h6000_1000, 32'h1111_1000, 2'd0, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    chk("R6 req cleared", {31'd0, walk_req}, 32'd0);
    look(32'h6000_1234, 1'b1, 32'h1111_1234, "R6 filled hit");
    inval(1'b1, 32'h0);
  endtask

  task automatic t_inval;
    fill(32'h2300_0000, 32'hA500_0000, 2'd3, 1'b0, 1'b0, 32'h0);
    fill(32'h2345_6000, 32'hC000_1000, 2'd0, 1'b0, 1'b0, 32'h0);
    fill(32'h7700_0000, 32'hD000_0000, 2'd2, 1'b0, 1'b0, 32'h0);
    inval(1'b0, 32'h23FF_F000);
    look(32'h2300_0040, 1'b0, 32'h0, "R9 16M cleared");
    look(32'h2345_6ABC, 1'b1, 32'hC000_1ABC, "R9 4K kept");
    look(32'h7700_0010, 1'b1, 32'hD000_0010, "R9 other kept");
    inval(1'b1, 32'h0);
    look(32'h2345_6ABC, 1'b0, 32'h0, "R10 all cleared a");
    look(32'h7700_0010, 1'b0, 32'h0, "R10 all cleared b");
  endtask

  task automatic t_same_cycle;
    fill(32'h7000_0000, 32'h0100_0000, 2'd0, 1'b0, 1'b0, 32'h0);
    fill(32'h7100_0000, 32'h0200_0000, 2'd0, 1'b1, 1'b0, 32'h0);
    look(32'h7000_0000, 1'b0, 32'h0, "R11 old cleared");
    look(32'h7100_0000, 1'b0, 32'h0, "R11 fill dropped");
    fill(32'h7200_0000, 32'h0300_0000, 2'd0, 1'b0, 1'b0, 32'h0);
    fill(32'h7300_0000, 32'h0400_0000, 2'd0, 1'b0, 1'b1, 32'h7200_0000);
    look(32'h7200_0000, 1'b0, 32'h0, "R11 inval old");
    look(32'h7300_0008, 1'b1, 32'h0400_0008, "R11 fill kept");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0;
    fill_valid = 1'b0; fill_vpn = '0; fill_frame = '0; fill_size = '0;
    inv_va_valid = 1'b0; inv_vpn = '0; inv_all = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_replace;
    t_sizes;
    t_walk;
    t_inval;
    t_same_cycle;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule